// File: doc/BRIEF.md
# Slope-Extrapolating Gamma Table

This block corrects one colour channel of a pixel stream through a small table. Each table slot holds a 10-bit base level and a 6-bit slope. The slope is a tiny floating-point number. The upper bits of an incoming code pick one slot, and the lower bits say how many steps into that slot's interval the code lies. The output starts at the slot's base level and climbs by the slot's slope times the step count. The next slot is never consulted. Because of this, the top end of the last interval is not held anywhere: it follows from the last slot's base and slope. A steep slope may not be representable, so that implied top end can miss its intended value.

Software loads slots through a simple write port and can read any slot back through a registered read port. Pixels enter with a valid strobe and leave two clock edges later with their own valid strobe. A table-enable input selects the corrected path; when it is low, the code passes through unchanged with the same delay. Three instances serve a red, green and blue pipe.

Top module: `gamma_slope_lut`

## Requirements
- R1: After a synchronous active-low reset, out_valid and out_pix are 0, rd_data is 0, and every slot holds 0, so a corrected pixel reads 0.
- R2: A slot word packs the base level in bits 15:6 and the slope in bits 5:0. Of the slope, bits 5:4 are the exponent and bits 3:0 are the mantissa. A write with wr_en stores wr_data at wr_idx. rd_data shows the word at rd_idx one edge after rd_idx is sampled.
- R3: Pixel code bits 9:3 choose the slot and bits 2:0 give the step offset (0 to 7) inside its interval.
- R4: At step offset 0 the corrected output equals the slot's base level exactly.
- R5: The output is base + ((mantissa << exponent) * offset + 4) >> 3. This is a slope in eighths of an output step per input step, rounded half up, and it uses only the selected slot, never its neighbour.
- R6: A result above 1023 is clamped to 1023.
- R7: out_valid is high exactly two edges after pix_valid is sampled high, and low two edges after pix_valid is sampled low.
- R8: With lut_en low, out_pix equals pix_in with the same two-edge delay, and the table contents are left as they were.
- R9: While no valid pixel arrives, out_pix holds its last value.
- R10: Slot 127 covers codes 1016 to 1023 by extrapolation from its own base and slope; no further endpoint is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lut_en | input | 1 | 1: corrected path, 0: pass-through |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 7 | Slot to write |
| wr_data | input | 16 | Slot word {base, exponent, mantissa} |
| rd_idx | input | 7 | Slot to read back |
| rd_data | output | 16 | Slot word, registered |
| pix_valid | input | 1 | Pixel strobe |
| pix_in | input | 10 | Pixel code |
| out_valid | output | 1 | Corrected pixel strobe |
| out_pix | output | 10 | Corrected pixel |

## Verification
A full sweep of all 1024 codes runs over a table filled with varied bases and slopes. It covers every slot, every offset and every exponent, so index decode, slope scaling and rounding are each tested against an independent model. Hand-picked cases separate the two rounding choices: offset 4 at the smallest slope gives 1, and offset 3 gives 0. Another case shows that a slot sitting next to a very different neighbour is not blended toward it. A steep top slot shows clamping and the implied last endpoint. A pass-through sweep, followed by a readback, shows that the delay is shared and that the table is left untouched.

// File: rtl/gslut_pkg.sv
package gslut_pkg;
   typedef enum logic {
      SEL_PASS  = 1'b0,
      SEL_TABLE = 1'b1
   } gslut_sel_e;
endpackage

// File: rtl/gslut_table.sv
module gslut_table #(
   parameter int IDX_W  = 7,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              px_re,
   input  logic [IDX_W-1:0]  px_idx,
   output logic [WORD_W-1:0] px_word,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic [WORD_W-1:0] rb_word
);
   localparam int DEPTH = 1 << IDX_W;

   logic [WORD_W-1:0] slots [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
      end else if (wr_en) begin
         slots[wr_idx] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         px_word <= '0;
         rb_word <= '0;
      end else begin
         if (px_re) px_word <= slots[px_idx];
         rb_word <= slots[rb_idx];
      end
   end
endmodule

// File: rtl/gslut_eval.sv
module gslut_eval #(
   parameter int VAL_W         = 10,
   parameter int EXP_W         = 2,
   parameter int MAN_W         = 4,
   parameter int OFS_W         = 3,
   parameter bit ROUND_HALF_UP = 1'b1
) (
   input  logic [VAL_W+EXP_W+MAN_W-1:0] word,
   input  logic [OFS_W-1:0]             ofs,
   output logic [VAL_W-1:0]             level
);
   localparam int WORD_W = VAL_W + EXP_W + MAN_W;
   localparam int SLP_W  = MAN_W + (1 << EXP_W) - 1;
   localparam int PRD_W  = SLP_W + OFS_W;
   localparam int SUM_W  = VAL_W + OFS_W + 1;
   localparam logic [SUM_W-1:0] VMAX = SUM_W'((1 << VAL_W) - 1);

   if (SLP_W >= VAL_W) begin : g_bad_slope
      $error("gslut_eval: decoded slope too wide for output");
   end

   logic [VAL_W-1:0] base;
   logic [EXP_W-1:0] sexp;
   logic [MAN_W-1:0] sman;
   logic [SLP_W-1:0] slope;
   logic [PRD_W-1:0] prod;
   logic [SUM_W-1:0] acc;

   assign base  = word[WORD_W-1 -: VAL_W];
   assign sexp  = word[MAN_W +: EXP_W];
   assign sman  = word[MAN_W-1:0];
   assign slope = SLP_W'(sman) << sexp;
   assign prod  = PRD_W'(slope) * PRD_W'(ofs);

   if (ROUND_HALF_UP) begin : g_round
      localparam logic [SUM_W-1:0] HALF = SUM_W'(1 << (OFS_W - 1));
      always_comb acc = ({1'b0, base, {OFS_W{1'b0}}} + SUM_W'(prod) + HALF) >> OFS_W;
   end else begin : g_trunc
      always_comb acc = ({1'b0, base, {OFS_W{1'b0}}} + SUM_W'(prod)) >> OFS_W;
   end

   assign level = (acc > VMAX) ? VMAX[VAL_W-1:0] : acc[VAL_W-1:0];
endmodule

// File: rtl/gamma_slope_lut.sv
module gamma_slope_lut #(
   parameter int VAL_W         = 10,
   parameter int EXP_W         = 2,
   parameter int MAN_W         = 4,
   parameter int IDX_W         = 7,
   parameter int OFS_W         = 3,
   parameter bit ROUND_HALF_UP = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         lut_en,
   input  logic                         wr_en,
   input  logic [IDX_W-1:0]             wr_idx,
   input  logic [VAL_W+EXP_W+MAN_W-1:0] wr_data,
   input  logic [IDX_W-1:0]             rd_idx,
   output logic [VAL_W+EXP_W+MAN_W-1:0] rd_data,
   input  logic                         pix_valid,
   input  logic [IDX_W+OFS_W-1:0]       pix_in,
   output logic                         out_valid,
   output logic [VAL_W-1:0]             out_pix
);
   import gslut_pkg::*;

   localparam int WORD_W = VAL_W + EXP_W + MAN_W;
   localparam int IN_W   = IDX_W + OFS_W;

   if (IN_W < VAL_W) begin : g_bad_in
      $error("gamma_slope_lut: pixel code narrower than output");
   end
   if (OFS_W < 1) begin : g_bad_ofs
      $error("gamma_slope_lut: need at least one offset bit");
   end

   // stage 1: table read plus aligned side data
   logic              s1_valid;
   gslut_sel_e        s1_sel;
   logic [OFS_W-1:0]  s1_ofs;
   logic [VAL_W-1:0]  s1_pass;
   logic [WORD_W-1:0] s1_word;
   logic [VAL_W-1:0]  s1_level;

   gslut_table #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .px_re   (pix_valid && lut_en),
      .px_idx  (pix_in[IN_W-1 -: IDX_W]),
      .px_word (s1_word),
      .rb_idx  (rd_idx),
      .rb_word (rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_sel   <= SEL_PASS;
         s1_ofs   <= '0;
         s1_pass  <= '0;
      end else begin
         s1_valid <= pix_valid;
         if (pix_valid) begin
            s1_sel  <= lut_en ? SEL_TABLE : SEL_PASS;
            s1_ofs  <= pix_in[OFS_W-1:0];
            s1_pass <= pix_in[IN_W-1 -: VAL_W];
         end
      end
   end

   // stage 2: slope extrapolation, clamp, output register
   gslut_eval #(
      .VAL_W(VAL_W), .EXP_W(EXP_W), .MAN_W(MAN_W),
      .OFS_W(OFS_W), .ROUND_HALF_UP(ROUND_HALF_UP)
   ) u_eval (
      .word  (s1_word),
      .ofs   (s1_ofs),
      .level (s1_level)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) out_pix <= (s1_sel == SEL_TABLE) ? s1_level : s1_pass;
      end
   end
endmodule

// File: rtl/gamma_slope_lut_checker.sv
module gamma_slope_lut_checker #(
   parameter int VAL_W = 10,
   parameter int IN_W  = 10,
   parameter int IDX_W = 7,
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lut_en,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [WORD_W-1:0] wr_data,
   input logic [IDX_W-1:0]  rd_idx,
   input logic [WORD_W-1:0] rd_data,
   input logic              pix_valid,
   input logic [IN_W-1:0]   pix_in,
   input logic              out_valid,
   input logic [VAL_W-1:0]  out_pix
);
   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> ##2 out_valid);                                          // R7
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |-> ##2 !out_valid);                                        // R7
   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !lut_en) |-> ##2 (out_pix == $past(pix_in[IN_W-1 -: VAL_W], 2))); // R8
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |-> ##2 $stable(out_pix));                                  // R9
   AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en ##1 (rd_idx == $past(wr_idx)) |=> (rd_data == $past(wr_data, 2))); // R2
endmodule

bind gamma_slope_lut gamma_slope_lut_checker #(
   .VAL_W(VAL_W), .IN_W(IDX_W + OFS_W), .IDX_W(IDX_W), .WORD_W(VAL_W + EXP_W + MAN_W)
) u_checker (
   .clk(clk), .rst_n(rst_n), .lut_en(lut_en), .wr_en(wr_en), .wr_idx(wr_idx),
   .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .pix_valid(pix_valid),
   .pix_in(pix_in), .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/gamma_slope_lut_bench.sv
`timescale 1ns/1ps
module gamma_slope_lut_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lut_en = 1'b1;
   logic        wr_en = 1'b0;
   logic [6:0]  wr_idx = '0;
   logic [15:0] wr_data = '0;
   logic [6:0]  rd_idx = '0;
   logic [15:0] rd_data;
   logic        pix_valid = 1'b0;
   logic [9:0]  pix_in = '0;
   logic        out_valid;
   logic [9:0]  out_pix;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0] model [128];
   int    exp_q [$];
   string tag_q [$];
   int    last_exp = 0;

   always #2.5 clk = ~clk;

   gamma_slope_lut u_gamma_slope_lut (
      .clk(clk), .rst_n(rst_n), .lut_en(lut_en), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .pix_valid(pix_valid),
      .pix_in(pix_in), .out_valid(out_valid), .out_pix(out_pix)
   );

   function automatic int ref_level(input int code);
      int w, base, ex, mn, ofs, r;
      w    = int'(model[code / 8]);
      base = w / 64;
      ex   = (w / 16) % 4;
      mn   = w % 16;
      ofs  = code % 8;
      r    = base + ((mn * (1 << ex)) * ofs + 4) / 8;
      if (r > 1023) r = 1023;
      return r;
   endfunction

   task automatic check(input string tag, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic write_slot(input int idx, input int base, input int slope);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_idx  = 7'(idx);
      wr_data = 16'((base << 6) | slope);
      model[idx] = 16'((base << 6) | slope);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_slot(input string tag, input int idx, input int expv);
      @(negedge clk);
      rd_idx = 7'(idx);
      @(negedge clk);
      check(tag, int'(rd_data), expv);
   endtask

   // driver: drive one pixel, queue what must come out
   task automatic send(input int code, input bit en, input int expv, input string tag);
      @(negedge clk);
      pix_valid = 1'b1;
      pix_in    = 10'(code);
      lut_en    = en;
      exp_q.push_back(expv);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         pix_valid = 1'b0;
      end
   endtask

   // monitor: compare results in arrival order
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R7 unexpected output actual %0d expected none", out_pix);
         end else begin
            string t;
            int e;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            last_exp = e;
            check(t, int'(out_pix), e);
         end
      end
   end

   initial begin
      for (int i = 0; i < 128; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      check("R1 out_valid after reset", int'(out_valid), 0);
      check("R1 out_pix after reset", int'(out_pix), 0);
      check("R1 rd_data after reset", int'(rd_data), 0);
      @(negedge clk);
      rst_n = 1'b1;
      read_slot("R1 slot 40 cleared", 40, 0);
      send(500, 1'b1, 0, "R1 cleared slot gives 0");
      idle(4);

      // varied table
      for (int i = 0; i < 128; i++) write_slot(i, (i * 37 + 5) % 1024, (i * 11) % 64);
      write_slot(10, 100, 6'b00_0001);
      write_slot(11, 900, 6'b00_0000);
      write_slot(127, 1000, 6'b11_1111);
      read_slot("R2 readback slot 127", 127, 16'hFA3F);
      read_slot("R2 readback slot 10", 10, 16'h1901);

      send(80, 1'b1, 100, "R3/R4 slot 10 offset 0");
      send(88, 1'b1, 900, "R3/R4 slot 11 offset 0");
      send(83, 1'b1, 100, "R5 offset 3 rounds down");
      send(84, 1'b1, 101, "R5 offset 4 rounds half up");
      send(87, 1'b1, 101, "R5 no blend toward neighbour");
      send(1016, 1'b1, 1000, "R10 last slot base");
      send(1017, 1'b1, 1015, "R10 last slot offset 1");
      send(1018, 1'b1, 1023, "R6 clamp offset 2");
      send(1023, 1'b1, 1023, "R6/R10 implied endpoint clamped");
      idle(4);

      for (int c = 0; c < 1024; c++) send(c, 1'b1, ref_level(c), "R5 sweep");
      for (int c = 0; c < 1024; c++) send(c, 1'b0, c, "R8 pass sweep");
      send(683, 1'b0, 683, "R8 pass last");
      idle(6);
      check("R7 queue drained", exp_q.size(), 0);
      check("R9 out_pix held", int'(out_pix), last_exp);
      check("R7 out_valid low when idle", int'(out_valid), 0);
      read_slot("R8 table untouched by pass mode", 127, 16'hFA3F);
      read_slot("R2 readback slot 11", 11, 16'hE100);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule